// File: doc/BRIEF.md
# Function-Unit Register Dependency Matrix

This block keeps, for every function unit in an out-of-order core, the register identity of the instruction that unit currently holds. The function units store only operand values. Their register numbers sit in this matrix as one-hot bit rows, with one row per unit and a separate row segment for each operand slot: destination, first source and second source. At issue the binary register numbers are decoded and latched into the chosen row. From then on the unit only says "I want operand 1" or "I want operand 2". The row turns that request, once the port arbiter grants it, into the register-file read enable for the correct register. A write grant turns into the write enable for the latched destination in the same way.

Each latched bit acts as a set/reset flag. Issue sets it. A granted read, a granted write or a row clear resets it, and a set in the same cycle takes priority over any reset. OR-reductions of the rows give every register a pending-write flag and a pending-read flag, which hazard logic elsewhere can use.

Top module: `fu_reg_depmatrix`

## Requirements
- R1: After reset, no row holds any register bit: `rd_pend_o`, `wr_pend_o`, `rd_en1_o`, `rd_en2_o` and `wr_en_o` are all zero.
- R2: When `issue_i[f]` is high at a clock edge, row f latches bit `dst_i` of its destination slot if `dst_en_i` is high, bit `src1_i` of its first-source slot if `src1_en_i` is high, and bit `src2_i` of its second-source slot if `src2_en_i` is high. A slot whose enable is low is not set. Bit index equals the binary register number.
- R3: In the same cycle, `rd_en1_o[r]` is high exactly when some row f has `rd_req1_i[f]` and `go_rd1_i[f]` both high and holds register r in its first-source slot. A request without a grant, or a grant without a request, drives no enable.
- R4: The same rule as R3 applies to `rd_en2_o`, using `rd_req2_i`, `go_rd2_i` and the second-source slot.
- R5: In the same cycle, `wr_en_o[r]` is high exactly when some row f has `go_wr_i[f]` high and holds register r in its destination slot.
- R6: After a cycle in which row f's read of a source slot is granted (request and grant both high), that slot of row f is empty. After a cycle with `go_wr_i[f]` high, row f's destination slot is empty.
- R7: `wr_pend_o[r]` is the OR over all rows of destination bit r. `rd_pend_o[r]` is the OR over all rows of first-source and second-source bit r.
- R8: If a set from issue and a reset (grant or clear) reach the same bit in the same cycle, the bit ends up set.
- R9: `clear_i[f]` empties all three slots of row f and leaves the other rows unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | NUM_FU | Issue strobe, one per row |
| dst_en_i | input | 1 | Destination register present |
| dst_i | input | RW | Destination register number |
| src1_en_i | input | 1 | First source present |
| src1_i | input | RW | First source register number |
| src2_en_i | input | 1 | Second source present |
| src2_i | input | RW | Second source register number |
| rd_req1_i | input | NUM_FU | Unit requests operand 1 |
| go_rd1_i | input | NUM_FU | Port grant for operand 1 read |
| rd_req2_i | input | NUM_FU | Unit requests operand 2 |
| go_rd2_i | input | NUM_FU | Port grant for operand 2 read |
| go_wr_i | input | NUM_FU | Port grant for result write |
| clear_i | input | NUM_FU | Row clear on completion or cancel |
| rd_en1_o | output | NUM_REG | Register-file read enables, operand 1 port |
| rd_en2_o | output | NUM_REG | Register-file read enables, operand 2 port |
| wr_en_o | output | NUM_REG | Register-file write enables |
| rd_pend_o | output | NUM_REG | Per-register pending-read summary |
| wr_pend_o | output | NUM_REG | Per-register pending-write summary |

## Verification
The hardest case to reach is a set and a reset landing on the same row bit in one cycle. This happens when an issue arrives on a row in the same cycle as that row's clear, read grant or write grant, and it only exposes a fault when the newly written register number differs from, or matches, the one being released. Directed sequences re-issue a row while all of its reset sources are raised, once with matching and once with different register numbers. A long random phase then drives issue, requests, grants and clears on all rows together, with a behavioural model checking every output on every clock.

// File: rtl/fu_reg_depmatrix.sv
module fu_reg_depmatrix #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 16,
  localparam int RW     = $clog2(NUM_REG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FU-1:0]  issue_i,
  input  logic               dst_en_i,
  input  logic [RW-1:0]      dst_i,
  input  logic               src1_en_i,
  input  logic [RW-1:0]      src1_i,
  input  logic               src2_en_i,
  input  logic [RW-1:0]      src2_i,
  input  logic [NUM_FU-1:0]  rd_req1_i,
  input  logic [NUM_FU-1:0]  go_rd1_i,
  input  logic [NUM_FU-1:0]  rd_req2_i,
  input  logic [NUM_FU-1:0]  go_rd2_i,
  input  logic [NUM_FU-1:0]  go_wr_i,
  input  logic [NUM_FU-1:0]  clear_i,
  output logic [NUM_REG-1:0] rd_en1_o,
  output logic [NUM_REG-1:0] rd_en2_o,
  output logic [NUM_REG-1:0] wr_en_o,
  output logic [NUM_REG-1:0] rd_pend_o,
  output logic [NUM_REG-1:0] wr_pend_o
);

  logic [NUM_REG-1:0] dst_q [NUM_FU];
  logic [NUM_REG-1:0] s1_q  [NUM_FU];
  logic [NUM_REG-1:0] s2_q  [NUM_FU];

  wire [NUM_REG-1:0] dst_set = dst_en_i  ? (NUM_REG'(1) << dst_i)  : '0;
  wire [NUM_REG-1:0] s1_set  = src1_en_i ? (NUM_REG'(1) << src1_i) : '0;
  wire [NUM_REG-1:0] s2_set  = src2_en_i ? (NUM_REG'(1) << src2_i) : '0;

  wire [NUM_FU-1:0] gnt1 = rd_req1_i & go_rd1_i;
  wire [NUM_FU-1:0] gnt2 = rd_req2_i & go_rd2_i;

  for (genvar f = 0; f < NUM_FU; f++) begin : g_row
    wire rst_d  = clear_i[f] | go_wr_i[f];
    wire rst_s1 = clear_i[f] | gnt1[f];
    wire rst_s2 = clear_i[f] | gnt2[f];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dst_q[f] <= '0;
        s1_q[f]  <= '0;
        s2_q[f]  <= '0;
      end else begin
        dst_q[f] <= (issue_i[f] ? dst_set : '0) | (dst_q[f] & ~{NUM_REG{rst_d}});
        s1_q[f]  <= (issue_i[f] ? s1_set  : '0) | (s1_q[f]  & ~{NUM_REG{rst_s1}});
        s2_q[f]  <= (issue_i[f] ? s2_set  : '0) | (s2_q[f]  & ~{NUM_REG{rst_s2}});
      end
    end

    AST_S1_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt1[f] && !issue_i[f]) |=> s1_q[f] == '0); // R6
    AST_S2_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt2[f] && !issue_i[f]) |=> s2_q[f] == '0); // R6
    AST_DST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wr_i[f] && !issue_i[f]) |=> dst_q[f] == '0); // R6
    AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_i[f] && !issue_i[f]) |=> (dst_q[f] | s1_q[f] | s2_q[f]) == '0); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i[f] && clear_i[f] && dst_en_i) |=> dst_q[f][$past(dst_i)]); // R8
  end

  always_comb begin
    rd_en1_o  = '0;
    rd_en2_o  = '0;
    wr_en_o   = '0;
    rd_pend_o = '0;
    wr_pend_o = '0;
    for (int f = 0; f < NUM_FU; f++) begin
      if (gnt1[f])    rd_en1_o = rd_en1_o | s1_q[f];
      if (gnt2[f])    rd_en2_o = rd_en2_o | s2_q[f];
      if (go_wr_i[f]) wr_en_o  = wr_en_o  | dst_q[f];
      rd_pend_o = rd_pend_o | s1_q[f] | s2_q[f];
      wr_pend_o = wr_pend_o | dst_q[f];
    end
  end

  AST_ISSUE_MARKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_i != '0) && dst_en_i) |=> wr_pend_o[$past(dst_i)]); // R2
  AST_RD1_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt1 == '0) |-> rd_en1_o == '0); // R3
  AST_RD2_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt2 == '0) |-> rd_en2_o == '0); // R4
  AST_WR_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr_i == '0) |-> wr_en_o == '0); // R5
  AST_WR_WITHIN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o & ~wr_pend_o) == '0); // R7

endmodule

// File: tb/tb_fu_reg_depmatrix.sv
module tb_fu_reg_depmatrix;
  localparam int NF = 4;
  localparam int NR = 16;
  localparam int RW = $clog2(NR);
  localparam time PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [NF-1:0] issue_i = '0, rd_req1_i = '0, go_rd1_i = '0, rd_req2_i = '0, go_rd2_i = '0, go_wr_i = '0, clear_i = '0;
  logic dst_en_i = 0, src1_en_i = 0, src2_en_i = 0;
  logic [RW-1:0] dst_i = '0, src1_i = '0, src2_i = '0;
  logic [NR-1:0] rd_en1_o, rd_en2_o, wr_en_o, rd_pend_o, wr_pend_o;

  fu_reg_depmatrix #(.NUM_FU(NF), .NUM_REG(NR)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int md [NF][NR];
  int m1 [NF][NR];
  int m2 [NF][NR];

  task automatic chk(string req, string what, logic [NR-1:0] got, logic [NR-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [NR-1:0] e1, e2, ew, erp, ewp;
    e1 = '0; e2 = '0; ew = '0; erp = '0; ewp = '0;
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < NR; r++) begin
        if (rd_req1_i[f] && go_rd1_i[f] && m1[f][r] != 0) e1[r] = 1;
        if (rd_req2_i[f] && go_rd2_i[f] && m2[f][r] != 0) e2[r] = 1;
        if (go_wr_i[f] && md[f][r] != 0) ew[r] = 1;
        if (m1[f][r] != 0 || m2[f][r] != 0) erp[r] = 1;
        if (md[f][r] != 0) ewp[r] = 1;
      end
    chk({"R3 ", tag}, "rd_en1", rd_en1_o, e1);
    chk({"R4 ", tag}, "rd_en2", rd_en2_o, e2);
    chk({"R5 ", tag}, "wr_en", wr_en_o, ew);
    chk({"R7 ", tag}, "rd_pend", rd_pend_o, erp);
    chk({"R7 ", tag}, "wr_pend", wr_pend_o, ewp);
  endtask

  task automatic model_step();
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < NR; r++) begin
        bit sd, s1, s2;
        sd = issue_i[f] && dst_en_i && (int'(dst_i) == r);
        s1 = issue_i[f] && src1_en_i && (int'(src1_i) == r);
        s2 = issue_i[f] && src2_en_i && (int'(src2_i) == r);
        if (clear_i[f] || go_wr_i[f]) md[f][r] = 0;
        if (clear_i[f] || (rd_req1_i[f] && go_rd1_i[f])) m1[f][r] = 0;
        if (clear_i[f] || (rd_req2_i[f] && go_rd2_i[f])) m2[f][r] = 0;
        if (sd) md[f][r] = 1;
        if (s1) m1[f][r] = 1;
        if (s2) m2[f][r] = 1;
      end
  endtask

  task automatic tick(string tag);
    #1;
    compare(tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    issue_i = '0; rd_req1_i = '0; go_rd1_i = '0; rd_req2_i = '0; go_rd2_i = '0;
    go_wr_i = '0; clear_i = '0; dst_en_i = 0; src1_en_i = 0; src2_en_i = 0;
  endtask

  task automatic issue(int f, int d, int a, int b, bit de, bit ae, bit be);
    issue_i = '0; issue_i[f] = 1;
    dst_i = RW'(d); src1_i = RW'(a); src2_i = RW'(b);
    dst_en_i = de; src1_en_i = ae; src2_en_i = be;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < NR; r++) begin md[f][r] = 0; m1[f][r] = 0; m2[f][r] = 0; end
    @(negedge clk); @(negedge clk);
    chk("R1", "rd_pend at reset", rd_pend_o, '0);
    chk("R1", "wr_pend at reset", wr_pend_o, '0);
    rst_n = 1;
    @(negedge clk);
    go_wr_i = '1; rd_req1_i = '1; go_rd1_i = '1; rd_req2_i = '1; go_rd2_i = '1;
    #1;
    chk("R1", "rd_en1 after reset", rd_en1_o, '0);
    chk("R1", "wr_en after reset", wr_en_o, '0);
    tick("R1");
    idle();

    issue(0, 3, 5, 7, 1, 1, 1); tick("R2");
    issue(1, 5, 3, 3, 1, 1, 1); tick("R2");
    issue(2, 9, 11, 12, 1, 0, 1); tick("R2 slot enable");
    idle(); tick("R2");
    chk("R2", "wr_pend latched", wr_pend_o, NR'((1 << 3) | (1 << 5) | (1 << 9)));
    chk("R2", "rd_pend latched", rd_pend_o, NR'((1 << 5) | (1 << 7) | (1 << 3) | (1 << 12)));

    rd_req1_i[0] = 1; tick("R3 request alone");
    idle(); go_rd1_i[0] = 1; tick("R3 grant alone");
    idle(); rd_req1_i[0] = 1; go_rd1_i[0] = 1; tick("R3 granted");
    idle(); rd_req2_i[1] = 1; go_rd2_i[1] = 1; rd_req2_i[0] = 1; go_rd2_i[0] = 1; tick("R4 granted");
    idle(); tick("R6 sources released");
    chk("R6", "rd_pend after read grants", rd_pend_o, NR'((1 << 3) | (1 << 12)));
    go_wr_i[1] = 1; tick("R5 write grant");
    idle(); tick("R6 dest released");
    chk("R6", "wr_pend after write grant", wr_pend_o, NR'((1 << 3) | (1 << 9)));

    issue(2, 9, 4, 12, 1, 1, 1); clear_i[2] = 1; go_wr_i[2] = 1;
    rd_req2_i[2] = 1; go_rd2_i[2] = 1; tick("R8 same numbers");
    idle(); issue(2, 6, 8, 10, 1, 1, 1); clear_i[2] = 1; tick("R8 new numbers");
    idle(); tick("R8");
    chk("R8", "wr_pend after set-wins", wr_pend_o, NR'((1 << 3) | (1 << 6)));

    issue(3, 14, 15, 0, 1, 1, 1); tick("R9 setup");
    idle(); clear_i[0] = 1; tick("R9 clear row0");
    idle(); tick("R9");
    chk("R9", "wr_pend after row clear", wr_pend_o, NR'((1 << 6) | (1 << 14)));
    rd_req1_i = '1; go_rd1_i = '1; tick("R9 other row kept");
    idle();

    for (int i = 0; i < 3000; i++) begin
      issue_i   = NF'($urandom) & NF'($urandom);
      dst_i = RW'($urandom); src1_i = RW'($urandom); src2_i = RW'($urandom);
      dst_en_i = 1'($urandom); src1_en_i = 1'($urandom); src2_en_i = 1'($urandom);
      rd_req1_i = NF'($urandom); go_rd1_i = NF'($urandom);
      rd_req2_i = NF'($urandom); go_rd2_i = NF'($urandom);
      go_wr_i   = NF'($urandom) & NF'($urandom);
      clear_i   = NF'($urandom) & NF'($urandom) & NF'($urandom);
      tick("R7 random");
    end
    idle(); tick("R7 final");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule